// File: doc/BRIEF.md
# Frame-Rate Sync Output Formatter

This block turns two frame-rate timing markers, one near 8 kHz and one near 2 kHz, into output signals. Each marker is a strobe one reference-clock cycle wide at the start of a frame. Every logic element runs on a single fast reference clock. Two timing paths, A and B, each supply one strobe per rate. A single select input decides which path feeds both channels.

The two rate channels have the same structure. Each has its own 2-bit shape field and its own enable. A channel can emit either a square wave or a pulse one reference cycle wide, and either form can be inverted. For the square wave, the channel counts the reference cycles between strobes. It then drops the output at half the length of the frame that has just ended. Settings and path changes are taken only at a frame strobe, so a change part-way through a frame never cuts a level short.

The block assumes the reference clock runs at 1.544 MHz or faster, so that a one-cycle pulse is much shorter than a frame.

Top module: `frame_sync_fmt`

## Requirements
- R1: Shape field 00 gives a non-inverted square wave. Take the frame that starts at a strobe edge and call the length of the previous frame N cycles. The output is high for the first floor(N/2) cycles after that strobe edge (at least 1) and then low until the next strobe.
- R2: Shape field 10 gives the same square wave as R1 with the opposite polarity.
- R3: Shape field 01 gives a non-inverted pulse. The output is high for exactly one reference cycle, the cycle just after the strobe edge, and low for the rest of the frame.
- R4: Shape field 11 gives the same pulse as R3 with the opposite polarity. The output is low for one cycle and high for the rest.
- R5: Square-wave mode needs a measured frame. The first strobe after reset, and the first strobe of a newly selected path, give an idle frame. Pulse mode produces its pulse at the first strobe after reset.
- R6: Between reset and the first strobe, each output shows the idle level of the shape field currently applied: the value of field bit 1. This level follows changes to the field.
- R7: A change to a shape field or an enable during a frame does not alter the current frame. The new value is taken at the next strobe.
- R8: Path select 0 takes path A strobes and select 1 takes path B strobes. A new select value is taken at a strobe of the path currently in use. That strobe gives an idle frame, and the frame measurement starts again on the new path. Strobes on the path not in use have no effect on the output.
- R9: When the enable taken at a strobe is 0, the output stays at its idle level (shape bit 1) for the whole frame.
- R10: The half point is measured again at every strobe from the frame that just ended, so the output follows changes in frame length. If a strobe arrives in the same cycle as the half-point fall, the strobe wins and the output stays active.
- R11: The two channels are independent. Activity on one channel never changes the output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| path_sel_i | input | 1 | Strobe path select: 0 takes path A, 1 takes path B |
| frm8_a_i | input | 1 | 8 kHz frame strobe from path A |
| frm2_a_i | input | 1 | 2 kHz frame strobe from path A |
| frm8_b_i | input | 1 | 8 kHz frame strobe from path B |
| frm2_b_i | input | 1 | 2 kHz frame strobe from path B |
| mode8_i | input | 2 | 8 kHz shape field: bit 0 selects pulse, bit 1 selects inversion |
| mode2_i | input | 2 | 2 kHz shape field, same encoding as mode8_i |
| en8_i | input | 1 | 8 kHz output enable |
| en2_i | input | 1 | 2 kHz output enable |
| sync8_o | output | 1 | Shaped 8 kHz output |
| sync2_o | output | 1 | Shaped 2 kHz output |

## Verification
A frame strobe and the half-point fall of the square wave can land in the same reference cycle. The bench makes this happen by following an 8-cycle frame with a 4-cycle frame, so that the next strobe arrives exactly when the count reaches the half point of 4. It checks that the output stays active through that edge. It also checks that the frame after it uses a half point of 2, taken from the short frame. In a separate case, a strobe on the path not in use is placed in the middle of a selected frame, and the bench checks that the output does not change.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

   // Shape field layout: bit 1 inverts, bit 0 selects pulse over square wave
   typedef struct packed {
      logic inv;
      logic pulse;
   } fsf_mode_t;

   localparam int unsigned FSF_NUM_CH = 2;
   localparam int unsigned FSF_CH_8K  = 0;
   localparam int unsigned FSF_CH_2K  = 1;

endpackage

// File: rtl/fsf_path_mux.sv
module fsf_path_mux (
   input  logic sel_i,
   input  logic strb_a_i,
   input  logic strb_b_i,
   output logic strb_o
);

   always_comb begin
      strb_o = sel_i ? strb_b_i : strb_a_i;
   end

endmodule

// File: rtl/fsf_period_meter.sv
module fsf_period_meter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             strb_i,
   input  logic             restart_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             valid_o,
   output logic [CNT_W-1:0] half_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] half_calc;

   // Half of the frame just ended, never below one cycle
   always_comb begin
      half_calc = cnt_o >> 1;
      if (half_calc == '0) half_calc = CNT_ONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o   <= '0;
         valid_o <= 1'b0;
         half_o  <= CNT_ONE;
      end else if (strb_i) begin
         cnt_o <= CNT_ONE;
         if (restart_i) begin
            valid_o <= 1'b0;
         end else begin
            if (valid_o) half_o <= half_calc;
            valid_o <= 1'b1;
         end
      end else if (cnt_o != CNT_MAX) begin
         cnt_o <= cnt_o + CNT_ONE;
      end
   end

   AST_HALF_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (half_o != '0)); // R10

   AST_COUNT_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (cnt_o != '0)); // R10

endmodule

// File: rtl/fsf_shaper.sv
module fsf_shaper
   import fsf_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sel_i,
   input  fsf_mode_t        mode_i,
   input  logic             en_i,
   input  logic             strb_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] half_i,
   input  logic             valid_i,
   output logic             eff_sel_o,
   output logic             restart_o,
   output logic             sync_o
);

   logic      started;
   logic      sel_q;
   fsf_mode_t mode_q;
   logic      en_q;
   logic      act;
   logic      inv_now;

   // Before the first strobe the live inputs steer path and idle level
   always_comb begin
      eff_sel_o = started ? sel_q : sel_i;
      restart_o = strb_i && started && (sel_i != sel_q);
      inv_now   = started ? mode_q.inv : mode_i.inv;
      sync_o    = (en_q & act) ^ inv_now;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         started <= 1'b0;
         sel_q   <= 1'b0;
         mode_q  <= '0;
         en_q    <= 1'b0;
         act     <= 1'b0;
      end else if (strb_i) begin
         started <= 1'b1;
         sel_q   <= sel_i;
         mode_q  <= mode_i;
         en_q    <= en_i;
         if (restart_o) act <= 1'b0;
         else           act <= mode_i.pulse | valid_i;
      end else if (act) begin
         if (mode_q.pulse)          act <= 1'b0;
         else if (cnt_i == half_i)  act <= 1'b0;
      end
   end

   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act && mode_q.pulse && !strb_i) |=> !act); // R3

   AST_CLOCK_FALLS_AT_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act && !mode_q.pulse && !strb_i && (cnt_i == half_i)) |=> !act); // R1

   AST_CFG_HELD_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strb_i |=> ($stable(mode_q) && $stable(en_q) && $stable(sel_q))); // R7

   AST_IDLE_BEFORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !started |-> !act); // R6

   AST_SWITCH_FRAME_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_o |=> !act); // R8

endmodule

// File: rtl/frame_sync_fmt.sv
module frame_sync_fmt
   import fsf_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       path_sel_i,
   input  logic       frm8_a_i,
   input  logic       frm2_a_i,
   input  logic       frm8_b_i,
   input  logic       frm2_b_i,
   input  logic [1:0] mode8_i,
   input  logic [1:0] mode2_i,
   input  logic       en8_i,
   input  logic       en2_i,
   output logic       sync8_o,
   output logic       sync2_o
);

   localparam int unsigned NCH = FSF_NUM_CH;

   if (CNT_W < 4) begin : g_bad_width
      $error("frame_sync_fmt: CNT_W must be at least 4");
   end

   logic      strb_a [NCH];
   logic      strb_b [NCH];
   fsf_mode_t mode   [NCH];
   logic      en     [NCH];
   logic      sync   [NCH];

   always_comb begin
      strb_a[FSF_CH_8K] = frm8_a_i;
      strb_a[FSF_CH_2K] = frm2_a_i;
      strb_b[FSF_CH_8K] = frm8_b_i;
      strb_b[FSF_CH_2K] = frm2_b_i;
      mode[FSF_CH_8K]   = mode8_i;
      mode[FSF_CH_2K]   = mode2_i;
      en[FSF_CH_8K]     = en8_i;
      en[FSF_CH_2K]     = en2_i;
      sync8_o           = sync[FSF_CH_8K];
      sync2_o           = sync[FSF_CH_2K];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic             eff_sel;
      logic             restart;
      logic             strb;
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] half;
      logic             valid;

      fsf_path_mux u_mux (
         .sel_i    (eff_sel),
         .strb_a_i (strb_a[c]),
         .strb_b_i (strb_b[c]),
         .strb_o   (strb)
      );

      fsf_period_meter #(.CNT_W(CNT_W)) u_meter (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .strb_i    (strb),
         .restart_i (restart),
         .cnt_o     (cnt),
         .valid_o   (valid),
         .half_o    (half)
      );

      fsf_shaper #(.CNT_W(CNT_W)) u_shape (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .sel_i     (path_sel_i),
         .mode_i    (mode[c]),
         .en_i      (en[c]),
         .strb_i    (strb),
         .cnt_i     (cnt),
         .half_i    (half),
         .valid_i   (valid),
         .eff_sel_o (eff_sel),
         .restart_o (restart),
         .sync_o    (sync[c])
      );
   end

endmodule

// File: tb/tb_frame_sync_fmt.sv
module tb_frame_sync_fmt;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic [1:0] sa = '0;
   logic [1:0] sb = '0;
   logic [1:0] md8 = 2'b00;
   logic [1:0] md2 = 2'b00;
   logic       en8 = 1'b1;
   logic       en2 = 1'b1;
   logic       sync8;
   logic       sync2;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   frame_sync_fmt dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .path_sel_i (sel),
      .frm8_a_i   (sa[0]),
      .frm2_a_i   (sa[1]),
      .frm8_b_i   (sb[0]),
      .frm2_b_i   (sb[1]),
      .mode8_i    (md8),
      .mode2_i    (md2),
      .en8_i      (en8),
      .en2_i      (en2),
      .sync8_o    (sync8),
      .sync2_o    (sync2)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic outp(input int ch);
      return (ch == 0) ? sync8 : sync2;
   endfunction

   task automatic chk(input logic got, input logic exp, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", what, got, exp);
      end
   endtask

   // One frame on channel ch; output high (before inversion) for samples 1..hi
   task automatic frame(input int ch, input bit on_b, input int n, input int hi,
                        input bit inv, input int mid_mode, input bit noise,
                        input string tag);
      logic other0;
      other0 = outp(1 - ch);
      if (on_b) sb[ch] = 1'b1; else sa[ch] = 1'b1;
      for (int j = 1; j <= n; j++) begin
         step();
         sa[ch] = 1'b0;
         sb[ch] = 1'b0;
         chk(outp(ch), logic'(j <= hi) ^ inv, $sformatf("%s sample %0d", tag, j));
         if (j == 2 && mid_mode >= 0) begin
            if (ch == 0) md8 = mid_mode[1:0]; else md2 = mid_mode[1:0];
         end
         if (j == 3 && noise) begin
            if (on_b) sa[ch] = 1'b1; else sb[ch] = 1'b1;
         end
      end
      chk(outp(1 - ch), other0, $sformatf("R11 other channel steady during %s", tag));
   endtask

   task automatic t_reset();
      repeat (3) step();
      chk(sync8, 1'b0, "R6 reset level 8k shape 00");
      rst_n = 1'b1;
      step();
      chk(sync8, 1'b0, "R6 idle 8k after reset shape 00");
      md8 = 2'b10;
      md2 = 2'b11;
      step();
      chk(sync8, 1'b1, "R6 idle 8k follows inverted shape");
      chk(sync2, 1'b1, "R6 idle 2k follows inverted shape");
      md8 = 2'b00;
      md2 = 2'b00;
      step();
      chk(sync8, 1'b0, "R6 idle 8k back to 00");
   endtask

   task automatic t_clock_8k();
      frame(0, 0, 10, 0, 0, -1, 0, "R5 first strobe, square wave idle");
      frame(0, 0, 10, 5, 0, -1, 0, "R1 square wave N=10");
      frame(0, 0, 7, 5, 0, -1, 0, "R10 short frame uses previous N=10");
      frame(0, 0, 8, 3, 0, -1, 0, "R10 half from N=7");
      frame(0, 0, 8, 4, 0, 1, 0, "R7 shape change mid-frame ignored");
   endtask

   task automatic t_pulse_8k();
      frame(0, 0, 8, 1, 0, -1, 0, "R3 pulse after latched change");
      md8 = 2'b11;
      frame(0, 0, 8, 1, 1, -1, 0, "R4 inverted pulse");
   endtask

   task automatic t_inv_and_coincide();
      md8 = 2'b10;
      frame(0, 0, 8, 4, 1, -1, 0, "R2 inverted square wave");
      frame(0, 0, 4, 4, 1, -1, 0, "R10 strobe on fall cycle keeps active");
      frame(0, 0, 6, 2, 1, -1, 0, "R10 half from N=4");
   endtask

   task automatic t_enable();
      en8 = 1'b0;
      frame(0, 0, 8, 0, 1, -1, 0, "R9 disabled holds idle");
      en8 = 1'b1;
      frame(0, 0, 8, 4, 1, -1, 0, "R9 re-enabled square wave");
   endtask

   task automatic t_path_switch();
      sel = 1'b1;
      frame(0, 0, 8, 0, 1, -1, 0, "R8 switching strobe gives idle frame");
      frame(0, 1, 8, 0, 1, -1, 1, "R8 first B strobe idle, A strobe ignored");
      frame(0, 1, 8, 4, 1, -1, 1, "R8 B path square wave, A strobe ignored");
   endtask

   task automatic t_second_channel();
      md2 = 2'b01;
      frame(1, 1, 12, 1, 0, -1, 0, "R5 2k pulse on first strobe");
      md2 = 2'b00;
      frame(1, 1, 12, 6, 0, -1, 0, "R1 2k square wave N=12");
      frame(1, 1, 12, 6, 0, -1, 0, "R11 2k square wave repeat");
   endtask

   initial begin
      t_reset();
      t_clock_8k();
      t_pulse_8k();
      t_inv_and_coincide();
      t_enable();
      t_path_switch();
      t_second_channel();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule